// File: doc/BRIEF.md
# Selectable-Source Frame Tag Counter

This block keeps a 32-bit tag value that is stamped onto data frames as they are detected. The tag advances by one in any core-clock cycle where at least one selected increment source fires. There are three sources: a periodic tick from a built-in period timer, rising edges of an asynchronous external clock, and a force mode that advances the tag on every core cycle. A control byte picks the sources. Raising the force bit for exactly one cycle therefore moves the tag by exactly one step.

The period timer counts core cycles from zero. When its count reaches the programmed match value it pulses a one-cycle tick and restarts from zero. The external clock is brought into the core clock domain through a two-flop synchroniser, and a rising-edge detector follows it. A synchronous clear zeroes both the tag and the timer. Loading the tag from a bus is not part of this block.

Top module: `tag_stamp_counter`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, the tag reads 0 and the timer count is 0. With a nonzero match value, the tick is low right after reset.
- R2: The timer count rises by one every core cycle. The tick is high exactly in the cycle where the count equals the match value M, and the count then restarts at 0. This gives one tick every M+1 cycles, the first one M cycles after a clear. With M = 0 the tick is high every cycle.
- R3: If the match value is lowered below the current count, the tick rises in that same cycle and the count returns to 0 at the next edge.
- R4: With control bit 3 (force) set, the tag increases by one at every core clock edge. Setting the bit for one cycle and then clearing it advances the tag by exactly one.
- R5: With control bit 0 or control bit 1 set, the tag increases by one at each core clock edge where the tick is high.
- R6: With control bit 2 set, each rising edge of the external clock advances the tag by one. The edge is counted at the third core edge after the input changes (two synchroniser stages, then edge detection). The external clock must hold each level for at least two core cycles.
- R7: When several sources fire in the same cycle, the tag still rises by only one. Control bits 7:4 have no effect, and with bits 3:0 all zero the tag holds its value.
- R8: A synchronous clear sets the tag and the timer count to 0 at the next edge, and it overrides any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of tag and timer |
| ctrl_i | input | 8 | Source select: bit0/bit1 timer tick, bit2 external edge, bit3 force; bits 7:4 unused |
| match_i | input | 32 | Period timer match value |
| ext_clk_i | input | 1 | Asynchronous external clock |
| tag_o | output | 32 | Current tag value |
| tick_o | output | 1 | One-cycle pulse when the timer reaches its match value |

## Verification
The assertions check the following on every cycle:
- the timer's step-by-one and its wrap after a tick;
- that an external edge pulse never lasts two cycles;
- that the tag moves by at most one per cycle;
- that force mode always adds exactly one;
- that a clear always wins;
- that the tag holds when no source is selected.

Only the bench's scenarios can show the exact tick spacing for a given match value, the three-edge latency of external edges, and the single-step behaviour of a one-cycle force pulse. A cycle-accurate reference model then follows random mixes of sources, match values, clears and external toggles.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int CTRL_W       = 8;
  localparam int SEL_TICK_A   = 0;
  localparam int SEL_TICK_B   = 1;
  localparam int SEL_EXT      = 2;
  localparam int SEL_FORCE    = 3;
  localparam int SEL_BITS     = 4;
endpackage

// File: rtl/ftc_period_timer.sv
module ftc_period_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] match_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             reach;

  assign reach  = (cnt_q >= match_i);
  assign tick_o = reach;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (clr_i || reach) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_o) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R2
endmodule

// File: rtl/ftc_edge_sync.sv
module ftc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/ftc_tag_accum.sv
module ftc_tag_accum #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;

  assign tag_en = clr_i | inc_i;

  always_comb begin
    tag_d = tag_q;
    if (clr_i)      tag_d = '0;
    else if (inc_i) tag_d = tag_q + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_d;
  end

  assign tag_o = tag_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (tag_o == '0)); // R8

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((tag_o == $past(tag_o)) || (tag_o == TAG_W'($past(tag_o) + TAG_W'(1))))); // R7
endmodule

// File: rtl/tag_stamp_counter.sv
module tag_stamp_counter
  import ftc_pkg::*;
#(
  parameter int TAG_W       = 32,
  parameter int MATCH_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic               ext_clk_i,
  output logic [TAG_W-1:0]   tag_o,
  output logic               tick_o
);
  logic tick;
  logic ext_rise;
  logic tick_sel;
  logic inc;
  logic unused_rsvd;

  assign unused_rsvd = ^ctrl_i[CTRL_W-1:SEL_BITS];

  ftc_period_timer #(.CNT_W(MATCH_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .match_i (match_i),
    .tick_o  (tick)
  );

  ftc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  assign tick_sel = ctrl_i[SEL_TICK_A] | ctrl_i[SEL_TICK_B];
  assign inc      = (tick_sel & tick)
                  | (ctrl_i[SEL_EXT] & ext_rise)
                  | ctrl_i[SEL_FORCE];

  ftc_tag_accum #(.TAG_W(TAG_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .inc_i (inc),
    .tag_o (tag_o)
  );

  assign tick_o = tick;

  AST_FORCE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ctrl_i[SEL_FORCE]) |=> (tag_o == TAG_W'($past(tag_o) + TAG_W'(1)))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (ctrl_i[SEL_BITS-1:0] == '0)) |=> $stable(tag_o)); // R7

  AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && tick_sel && tick_o) |=> (tag_o == TAG_W'($past(tag_o) + TAG_W'(1)))); // R5
endmodule

// File: tb/test_tag_stamp_counter.sv
module test_tag_stamp_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic [7:0]  ctrl_i = 8'h01;
  logic [31:0] match_i = 32'd4;
  logic        ext_clk_i = 1'b0;
  logic [31:0] tag_o;
  logic        tick_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  tag_stamp_counter i_tag_stamp_counter (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ctrl_i(ctrl_i),
    .match_i(match_i), .ext_clk_i(ext_clk_i), .tag_o(tag_o), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model of the requirements
  logic [31:0] m_tag, m_cnt;
  logic        m_e1, m_e2, m_e3;

  function automatic bit exp_tick(input logic [31:0] cnt, input logic [31:0] m);
    return cnt >= m;
  endfunction

  function automatic bit exp_inc(input logic [7:0] c, input bit tk, input bit rise);
    return ((c[0] | c[1]) & tk) | (c[2] & rise) | c[3];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tag = '0; m_cnt = '0; m_e1 = 0; m_e2 = 0; m_e3 = 0;
    end else begin
      bit tk, rs;
      tk = exp_tick(m_cnt, match_i);
      rs = m_e2 & ~m_e3;
      if (clr_i) m_tag = '0;
      else if (exp_inc(ctrl_i, tk, rs)) m_tag = m_tag + 1;
      m_cnt = (clr_i || tk) ? 32'd0 : m_cnt + 1;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_i;
    end
  end

  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check(cur_req, "model tag", tag_o, m_tag);
      check(cur_req, "model tick", {31'd0, tick_o}, {31'd0, exp_tick(m_cnt, match_i)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr_i = 1'b1; step(1); clr_i = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    int ticks;
    void'($urandom(32'd1234));

    // R1 reset state
    step(2);
    #1;
    check("R1", "tag in reset", tag_o, 32'd0);
    check("R1", "tick in reset", {31'd0, tick_o}, 32'd0);
    ctrl_i = 8'h00;
    rst_n = 1'b1;
    step(1); #1;
    check("R1", "tag after reset", tag_o, 32'd0);

    // R2 tick spacing with M=4
    cur_req = "R2";
    match_i = 32'd4;
    do_clear();
    ticks = 0;
    for (int i = 0; i < 25; i++) begin
      #(CLK_PERIOD/4);
      if (tick_o) ticks++;
      step(1);
    end
    check("R2", "ticks in 25 cycles M=4", ticks, 32'd5);
    match_i = 32'd0;
    ticks = 0;
    for (int i = 0; i < 10; i++) begin
      #(CLK_PERIOD/4);
      if (tick_o) ticks++;
      step(1);
    end
    check("R2", "ticks in 10 cycles M=0", ticks, 32'd10);

    // R3 lowering match below count
    cur_req = "R3";
    match_i = 32'd20;
    do_clear();
    step(3);
    match_i = 32'd1;
    #1;
    check("R3", "tick at lowered match", {31'd0, tick_o}, 32'd1);
    step(1); #1;
    check("R3", "tick after wrap", {31'd0, tick_o}, 32'd0);
    step(1); #1;
    check("R3", "tick at count 1", {31'd0, tick_o}, 32'd1);

    // R4 single step by force pulse
    cur_req = "R4";
    match_i = 32'd4;
    base = tag_o;
    ctrl_i = 8'h08; step(1);
    ctrl_i = 8'h00; step(3); #1;
    check("R4", "single force step", tag_o, base + 1);
    base = tag_o;
    ctrl_i = 8'h08; step(7);
    ctrl_i = 8'h00; step(1); #1;
    check("R4", "force 7 cycles", tag_o, base + 7);

    // R5 timer tick source via bit 1 then bit 0
    cur_req = "R5";
    clr_i = 1'b1; ctrl_i = 8'h02; step(1); clr_i = 1'b0;
    step(20); ctrl_i = 8'h00; #1;
    check("R5", "bit1 ticks in 20 cycles", tag_o, 32'd4);
    clr_i = 1'b1; ctrl_i = 8'h01; step(1); clr_i = 1'b0;
    step(10); ctrl_i = 8'h00; #1;
    check("R5", "bit0 ticks in 10 cycles", tag_o, 32'd2);

    // R6 external edges
    cur_req = "R6";
    ext_clk_i = 1'b0;
    clr_i = 1'b1; ctrl_i = 8'h04; step(4); clr_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ext_clk_i = 1'b1; step(4);
      ext_clk_i = 1'b0; step(4);
    end
    #1;
    check("R6", "three external edges", tag_o, 32'd3);
    ext_clk_i = 1'b1; step(2); #1;
    check("R6", "edge not yet counted", tag_o, 32'd3);
    step(1); #1;
    check("R6", "edge counted at third edge", tag_o, 32'd4);
    ext_clk_i = 1'b0; step(4);

    // R7 combination and reserved bits
    cur_req = "R7";
    base = tag_o;
    ctrl_i = 8'h0F; match_i = 32'd0; ext_clk_i = 1'b1;
    step(10); #1;
    check("R7", "all sources one per cycle", tag_o, base + 10);
    base = tag_o;
    ctrl_i = 8'hF0; ext_clk_i = 1'b0; step(3);
    ext_clk_i = 1'b1; step(6); #1;
    check("R7", "reserved bits no effect", tag_o, base);
    ext_clk_i = 1'b0;

    // R8 clear overrides force
    cur_req = "R8";
    ctrl_i = 8'h08; step(3);
    clr_i = 1'b1; step(1); clr_i = 1'b0; ctrl_i = 8'h00; #1;
    check("R8", "clear beats force", tag_o, 32'd0);

    // Random mix against model
    cur_req = "R7";
    match_i = 32'd3;
    for (int i = 0; i < 1500; i++) begin
      clr_i = (($urandom % 40) == 0);
      if (($urandom % 16) == 0) ctrl_i = 8'($urandom);
      if (($urandom % 50) == 0) match_i = $urandom % 8;
      if (($urandom % 3) == 0)  ext_clk_i = 1'($urandom);
      step(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule